// File: doc/BRIEF.md
# Dual-Loop PI PWM Controller

This block is the digital control core for a single-inductor converter that feeds two stacked outputs. It receives sampled words for the voltage on the first output capacitor and for the sum of both output voltages, together with a target for each. Two separate fixed-point proportional-integral loops turn these into duty values, one duty value for each power switch.

Each duty value is compared against its own up-counting sawtooth, and the comparison gives the gate drive. The capacitor loop drives the first switch from a carrier of `PER` clocks. The total-voltage loop drives the second switch from a carrier that counts the same clock over `PER/2` clocks, so it runs at twice the frequency. For example, `PER` = 10000 at 50 MHz gives 5 kHz and 10 kHz.

Both loops compute only on a one-cycle sample strobe. A new duty value is taken up by the comparator only when its carrier wraps, so each carrier period carries exactly one pulse. Each integrator is bounded to its own carrier range and stops accumulating while the output it feeds is clamped. This prevents windup. The default fixed-point scale is `FRAC` = 4, so products are divided by 16 with an arithmetic shift, rounding towards minus infinity.

Top module: `dual_pi_pwm`

## Requirements
- R1: While reset is low, and after reset until the first sample strobe, both gates stay low and both integrators hold zero.
- R2: For each loop the error is the reference minus the measurement, with both taken as unsigned words. The proportional term is floor(kp*error/2^FRAC).
- R3: On each strobe the integrator adds floor(ki*error/2^FRAC). The duty value produced by that strobe uses the integrator value held before the strobe.
- R4: The duty is proportional term plus integrator, clamped to 0..L. L is `PER` for the capacitor loop and `PER/2` for the total loop. Within each carrier period the gate is high while the carrier count, which starts at 0, is below the active duty. So the gate is high for exactly duty clocks: 0 gives no pulse and L gives a gate that stays high.
- R5: Each integrator stays within 0..L. It is left unchanged on a strobe where the unclamped output is above L and the step is positive, or below 0 and the step is negative.
- R6: Without a strobe, changes on the reference, measurement and gain inputs do not change either gate pattern.
- R7: The capacitor-voltage loop drives `gate_s1`, whose carrier period is `PER` clocks. The total-voltage loop drives `gate_s2`, whose carrier period is `PER/2` clocks.
- R8: A new duty value takes effect only at the start of the next carrier period, so every period has at most one rising gate edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe: a new sample set is valid |
| ref_cap | input | DW | Target for the first output capacitor voltage |
| meas_cap | input | DW | Sampled first output capacitor voltage |
| kp_cap | input | GW | Proportional gain, capacitor loop |
| ki_cap | input | GW | Integral gain, capacitor loop |
| ref_sum | input | DW | Target for the total output voltage |
| meas_sum | input | DW | Sampled total output voltage |
| kp_sum | input | GW | Proportional gain, total loop |
| ki_sum | input | GW | Integral gain, total loop |
| gate_s1 | output | 1 | Gate drive of the first switch (slow carrier) |
| gate_s2 | output | 1 | Gate drive of the second switch (fast carrier) |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume that the strobe is the only event that can move the stored duty values; the inputs may otherwise change freely. The stimulus changes references, measurements and gains only on the falling clock edge. It raises the strobe for exactly one cycle at a time and leaves several carrier periods before it counts gate-high clocks, so every measurement window sees a single settled duty value. The test of duty update at the period boundary lines the strobe up with the falling edge of the first gate. The strobe then lands in the part of the period where an immediate update would add a second pulse.

// File: rtl/dual_pi_pwm.sv
module dual_pi_pwm #(
  parameter int DW   = 12,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  parameter int PER  = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [DW-1:0] ref_cap,
  input  logic [DW-1:0] meas_cap,
  input  logic [GW-1:0] kp_cap,
  input  logic [GW-1:0] ki_cap,
  input  logic [DW-1:0] ref_sum,
  input  logic [DW-1:0] meas_sum,
  input  logic [GW-1:0] kp_sum,
  input  logic [GW-1:0] ki_sum,
  output logic          gate_s1,
  output logic          gate_s2
);
  localparam int HALF = PER / 2;
  localparam int CW   = $clog2(PER + 1);
  localparam int EW   = DW + 1;
  localparam int MW   = EW + GW + 1;
  localparam int SW   = MW + 2;
  localparam logic [1:0][CW-1:0] LIM = {CW'(HALF), CW'(PER)};
  localparam logic [1:0][CW-1:0] TOP = {CW'(HALF - 1), CW'(PER - 1)};

  logic [1:0][DW-1:0] ref_v, meas_v;
  logic [1:0][GW-1:0] kp_v, ki_v;
  assign ref_v  = {ref_sum, ref_cap};
  assign meas_v = {meas_sum, meas_cap};
  assign kp_v   = {kp_sum, kp_cap};
  assign ki_v   = {ki_sum, ki_cap};

  logic [1:0][CW-1:0] cnt, duty_q, duty_act, duty_nx;
  logic [1:0]         gate_q;
  logic signed [SW-1:0] integ    [2];
  logic signed [SW-1:0] integ_nx [2];

  always_comb begin
    for (int k = 0; k < 2; k++) begin : loop_math
      logic signed [EW-1:0] e;
      logic signed [MW-1:0] pp, ip;
      logic signed [SW-1:0] pt, st, u, c, lim;
      logic hi, lo, up, dn;
      e   = $signed({1'b0, ref_v[k]}) - $signed({1'b0, meas_v[k]});
      pp  = MW'(e) * MW'($signed({1'b0, kp_v[k]}));
      ip  = MW'(e) * MW'($signed({1'b0, ki_v[k]}));
      pt  = SW'(pp >>> FRAC);
      st  = SW'(ip >>> FRAC);
      lim = $signed(SW'(LIM[k]));
      u   = pt + integ[k];
      c   = integ[k] + st;
      lo  = u[SW-1];
      hi  = !lo && (u > lim);
      up  = !st[SW-1] && (st != '0);
      dn  = st[SW-1];
      duty_nx[k] = hi ? LIM[k] : (lo ? '0 : u[CW-1:0]);
      if ((hi && up) || (lo && dn))
        integ_nx[k] = integ[k];
      else if (c[SW-1])
        integ_nx[k] = '0;
      else if (c > lim)
        integ_nx[k] = lim;
      else
        integ_nx[k] = c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_q   <= '0;
      duty_act <= '0;
      gate_q   <= '0;
      integ[0] <= '0;
      integ[1] <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (cnt[k] == TOP[k]) begin
          cnt[k]      <= '0;
          duty_act[k] <= duty_q[k];
        end else begin
          cnt[k] <= cnt[k] + CW'(1);
        end
        gate_q[k] <= (cnt[k] < duty_act[k]);
        if (smp_stb) begin
          duty_q[k] <= duty_nx[k];
          integ[k]  <= integ_nx[k];
        end
      end
    end
  end

  assign gate_s1 = gate_q[0];
  assign gate_s2 = gate_q[1];
endmodule

// File: rtl/dual_pi_pwm_chk.sv
module dual_pi_pwm_chk #(
  parameter int PER = 10000,
  parameter int CW  = 14,
  parameter int SW  = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 gate_s1,
  input logic                 gate_s2,
  input logic [1:0][CW-1:0]   cnt,
  input logic [1:0][CW-1:0]   duty_q,
  input logic [1:0][CW-1:0]   duty_act,
  input logic signed [SW-1:0] integ0,
  input logic signed [SW-1:0] integ1
);
  localparam logic signed [SW-1:0] LA = SW'(PER);
  localparam logic signed [SW-1:0] LB = SW'(PER / 2);
  localparam logic [CW-1:0] TA = CW'(PER - 1);
  localparam logic [CW-1:0] TB = CW'(PER / 2 - 1);
  localparam logic [CW-1:0] FA = CW'(PER);
  localparam logic [CW-1:0] FB = CW'(PER / 2);

  a_r4_zero_duty_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[0] == '0) |=> !gate_s1);
  a_r4_zero_duty_s2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[1] == '0) |=> !gate_s2);
  a_r4_full_duty_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[0] == FA) |=> gate_s1);
  a_r4_full_duty_s2: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act[1] == FB) |=> gate_s2);
  a_r5_integ_range: assert property (@(posedge clk) disable iff (!rst_n)
    !integ0[SW-1] && (integ0 <= LA) && !integ1[SW-1] && (integ1 <= LB));
  a_r6_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(duty_q));
  a_r7_carrier_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= TA) && (cnt[1] <= TB));
  a_r7_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[1] != TB) |=> (cnt[1] == $past(cnt[1]) + CW'(1)));
  a_r8_load_at_wrap_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] != TA) |=> $stable(duty_act[0]));
  a_r8_load_at_wrap_s2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[1] != TB) |=> $stable(duty_act[1]));
endmodule

bind dual_pi_pwm dual_pi_pwm_chk #(.PER(PER), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
  .gate_s1(gate_s1), .gate_s2(gate_s2),
  .cnt(cnt), .duty_q(duty_q), .duty_act(duty_act),
  .integ0(integ[0]), .integ1(integ[1])
);

// File: tb/dual_pi_pwm_tb.sv
module dual_pi_pwm_tb;
  localparam int PER  = 40;
  localparam int HALF = PER / 2;
  localparam int FRAC = 4;
  localparam int NV   = 6;
  // ref_c, meas_c, kp_c, ki_c, ref_s, meas_s, kp_s, ki_s, duty_s1, duty_s2
  localparam int VEC [NV][10] = '{
    '{100,   90,  32, 0,  200,  195,  16, 0, 20,  5},
    '{ 90,  100,  32, 0,  200,  100,  16, 0,  0, 20},
    '{500,  400,  16, 0,   50,   48,  40, 0, 40,  5},
    '{100,   99,  24, 0,  300,  300,  50, 0,  1,  0},
    '{100,   97, 100, 0, 4095, 4080,  20, 0, 18, 18},
    '{  0, 4095, 255, 0, 4095,    0, 255, 0,  0, 20}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, smp_stb;
  logic [11:0] ref_cap, meas_cap, ref_sum, meas_sum;
  logic [7:0]  kp_cap, ki_cap, kp_sum, ki_sum;
  logic gate_s1, gate_s2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mi [2];

  dual_pi_pwm #(.DW(12), .GW(8), .FRAC(FRAC), .PER(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .ref_cap(ref_cap), .meas_cap(meas_cap), .kp_cap(kp_cap), .ki_cap(ki_cap),
    .ref_sum(ref_sum), .meas_sum(meas_sum), .kp_sum(kp_sum), .ki_sum(ki_sum),
    .gate_s1(gate_s1), .gate_s2(gate_s2)
  );

  function automatic int model(int k, int r, int m, int kp, int ki);
    int e, p, s, u, c, lim, d;
    lim = (k == 0) ? PER : HALF;
    e = r - m;
    p = (kp * e) >>> FRAC;
    s = (ki * e) >>> FRAC;
    u = p + mi[k];
    c = mi[k] + s;
    d = (u > lim) ? lim : ((u < 0) ? 0 : u);
    if (!((u > lim && s > 0) || (u < 0 && s < 0)))
      mi[k] = (c > lim) ? lim : ((c < 0) ? 0 : c);
    return d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cap(input int r, input int m, input int p, input int i);
    ref_cap = 12'(r); meas_cap = 12'(m); kp_cap = 8'(p); ki_cap = 8'(i);
  endtask

  task automatic set_sum(input int r, input int m, input int p, input int i);
    ref_sum = 12'(r); meas_sum = 12'(m); kp_sum = 8'(p); ki_sum = 8'(i);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mi[0] = 0;
    mi[1] = 0;
  endtask

  task automatic apply(output int da, output int db);
    @(negedge clk) smp_stb = 1'b1;
    @(negedge clk) smp_stb = 1'b0;
    da = model(0, int'(ref_cap), int'(meas_cap), int'(kp_cap), int'(ki_cap));
    db = model(1, int'(ref_sum), int'(meas_sum), int'(kp_sum), int'(ki_sum));
  endtask

  task automatic count_high(output int ha, output int hb);
    ha = 0; hb = 0;
    repeat (PER) begin
      @(negedge clk);
      if (gate_s1) ha++;
      if (gate_s2) hb++;
    end
  endtask

  task automatic measure(output int ha, output int hb);
    repeat (2 * PER + 4) @(negedge clk);
    count_high(ha, hb);
  endtask

  task automatic rise_gap(input bit fast, output int gap);
    bit p, g, r;
    p = fast ? gate_s2 : gate_s1;
    do begin
      @(negedge clk); g = fast ? gate_s2 : gate_s1; r = g && !p; p = g;
    end while (!r);
    gap = 0;
    do begin
      @(negedge clk); gap++; g = fast ? gate_s2 : gate_s1; r = g && !p; p = g;
    end while (!r && gap < 4 * PER);
  endtask

  initial begin
    int ha, hb, da, db, rises, gap;
    bit p, g;
    rst_n = 1'b0; smp_stb = 1'b0;
    set_cap(200, 100, 50, 50);
    set_sum(200, 100, 50, 50);
    mi[0] = 0; mi[1] = 0;

    // R1: gates low during reset and until the first strobe
    count_high(ha, hb);
    check("R1 s1 in reset", ha, 0);
    check("R1 s2 in reset", hb, 0);
    @(negedge clk) rst_n = 1'b1;
    measure(ha, hb);
    check("R1 s1 before strobe", ha, 0);
    check("R1 s2 before strobe", hb, 0);

    // R2 / R4: proportional-only vectors
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      set_cap(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      set_sum(VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);
      apply(da, db);
      measure(ha, hb);
      check($sformatf("R2/R4 vec%0d s1", v), ha, VEC[v][8]);
      check($sformatf("R2/R4 vec%0d s2", v), hb, 2 * VEC[v][9]);
    end

    // R3: integral accumulation with one-strobe lag
    do_reset();
    set_cap(103, 100, 0, 16);
    set_sum(100, 98, 0, 32);
    repeat (3) apply(da, db);
    measure(ha, hb);
    check("R3 s1 integral", ha, 6);
    check("R3 s2 integral", hb, 16);
    check("R3 model s1", ha, da);

    // R5: saturation of the integrator at the carrier range
    do_reset();
    set_cap(110, 100, 0, 255);
    set_sum(100, 100, 0, 0);
    repeat (5) apply(da, db);
    set_cap(99, 100, 0, 16);
    repeat (2) apply(da, db);
    measure(ha, hb);
    check("R5 s1 unwinds after saturation", ha, 39);
    check("R5 s2 idle", hb, 0);

    // R5: freeze while the output is clamped
    do_reset();
    set_cap(100, 100, 0, 0);
    set_sum(105, 100, 0, 16);
    repeat (2) apply(da, db);
    set_sum(105, 100, 64, 16);
    repeat (3) apply(da, db);
    set_sum(105, 100, 0, 0);
    apply(da, db);
    measure(ha, hb);
    check("R5 s2 frozen integrator", hb, 20);
    check("R5 model s2", hb, 2 * db);

    // R6: input changes without a strobe
    @(negedge clk);
    set_cap(4000, 0, 255, 255);
    set_sum(0, 4000, 255, 255);
    measure(ha, hb);
    check("R6 s1 no strobe", ha, 0);
    check("R6 s2 no strobe", hb, 20);

    // R7: carrier periods and loop-to-gate mapping
    do_reset();
    set_cap(100, 90, 32, 0);
    set_sum(110, 100, 16, 0);
    apply(da, db);
    measure(ha, hb);
    check("R7 s1 duty from capacitor loop", ha, 20);
    check("R7 s2 duty from total loop", hb, 20);
    rise_gap(1'b0, gap);
    check("R7 s1 period", gap, PER);
    rise_gap(1'b1, gap);
    check("R7 s2 period", gap, HALF);

    // R8: update lands at the period start, one pulse per period
    p = gate_s1;
    do begin
      @(negedge clk); g = gate_s1;
      if (!g && p) break;
      p = g;
    end while (1);
    p = 1'b0;
    rises = 0;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (i == 2) begin
        kp_cap = 8'd48;
        smp_stb = 1'b1;
      end else begin
        smp_stb = 1'b0;
      end
      g = gate_s1;
      if (g && !p) rises++;
      p = g;
    end
    da = model(0, int'(ref_cap), int'(meas_cap), int'(kp_cap), int'(ki_cap));
    check("R8 s1 rises in four periods", rises, 4);
    measure(ha, hb);
    check("R8 s1 new duty", ha, da);
    check("R8 s1 new duty value", ha, 30);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule